// File: doc/BRIEF.md
# Signed Integer to Double-Precision Converter

This block turns a 52-bit two's-complement integer into the 64-bit IEEE 754 double-precision bit pattern that encodes the same value. It is pure combinational logic with no clock. The sign is taken from the top input bit and the magnitude is formed by negating negative inputs. A leading-zero count, taken over the magnitude extended on the right with zero bits to 60 bits, drives a left barrel shift that puts the leading one in the top position. That leading one becomes the hidden bit. The shift count also gives the biased exponent.

A magnitude of at most 52 bits always fits in the 53-bit significand of a double, so the result is exact and the block has no rounding stage. The block is meant to sit in the path of a datapath that needs integer values in floating-point form within the same cycle. A zero input gives positive zero. The most negative input, -2^51, is handled through a 52-bit unsigned magnitude.

Top module: `int2dbl_conv`

## Requirements
- R1: An input of zero gives an all-zero output (positive zero).
- R2: For a nonzero input, output bit 63 (the sign) equals input bit 51. A set bit 51 marks a negative two's-complement value.
- R3: For a nonzero input, output bits 62:52 hold 1023 plus the bit position of the most significant one of the input's magnitude. Bit 0 is position 0.
- R4: Output bits 51:0 hold the magnitude bits below its leading one, left-aligned to bit 51, with zeros filling the low end.
- R5: The most negative input, 0x8000000000000 (value -2^51), gives 0xC320000000000000.
- R6: For every input, the output equals bit for bit the IEEE 754 double encoding of the input's signed integer value.
- R7: The exponent field is never all ones, and the output is never negative zero (0x8000000000000000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| int_in | input | 52 | Two's-complement integer to convert |
| dbl_out | output | 64 | IEEE 754 double-precision encoding of int_in |

## Verification
Some properties are checked as the inputs change. These are: zero maps to zero, the sign bit follows the input's top bit, the exponent field names the exact position of the magnitude's leading one, the fraction has no bits below the magnitude's width, and the output is never a special or negative-zero value. Bit-exact agreement with the double encoding of each value can only be shown by the bench's scenarios. These compare the output against the simulator's own real-to-bits conversion over random magnitudes of every length and both signs, and over the extreme values ±1, 2^51-1 and -2^51.

// File: rtl/int2dbl_pkg.sv
package int2dbl_pkg;
  localparam int DBL_W    = 64;
  localparam int EXP_W    = 11;
  localparam int FRAC_W   = 52;
  localparam int EXP_BIAS = 1023;
endpackage

// File: rtl/i2d_magnitude.sv
module i2d_magnitude #(
  parameter int W = 52
) (
  input  logic [W-1:0] value_i,
  output logic         neg_o,
  output logic [W-1:0] mag_o
);
  always_comb begin
    neg_o = value_i[W-1];
    // The most negative value negates to itself, which read unsigned is 2^(W-1).
    mag_o = neg_o ? (~value_i + W'(1)) : value_i;
  end
endmodule

// File: rtl/i2d_lzc.sv
module i2d_lzc #(
  parameter int W     = 60,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec_i,
  output logic [CNT_W-1:0] cnt_o
);
  // Priority scan from the bottom: the highest set bit writes last.
  // An all-zero vector gives the count W.
  always_comb begin
    cnt_o = CNT_W'(W);
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) cnt_o = CNT_W'(W - 1 - i);
    end
  end
endmodule

// File: rtl/i2d_lshift.sv
module i2d_lshift #(
  parameter int W    = 52,
  parameter int SH_W = 6
) (
  input  logic [W-1:0]    data_i,
  input  logic [SH_W-1:0] amt_i,
  output logic [W-1:0]    data_o
);
  logic [W-1:0] stage [SH_W+1];

  assign stage[0] = data_i;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    if (STEP >= W) begin : g_clear
      assign stage[s+1] = amt_i[s] ? '0 : stage[s];
    end else begin : g_move
      assign stage[s+1] = amt_i[s] ? {stage[s][W-1-STEP:0], {STEP{1'b0}}} : stage[s];
    end
  end

  assign data_o = stage[SH_W];
endmodule

// File: rtl/i2d_pack.sv
module i2d_pack
  import int2dbl_pkg::*;
#(
  parameter int INT_W = 52,
  parameter int CNT_W = 6
) (
  input  logic             neg_i,
  input  logic [CNT_W-1:0] lz_i,
  input  logic [INT_W-1:0] norm_i,
  output logic [DBL_W-1:0] dbl_o
);
  localparam int TOP_EXP = EXP_BIAS + INT_W - 1;
  localparam int PAD_W   = FRAC_W - INT_W + 1;

  logic             nonzero;
  logic [EXP_W-1:0] exp_f;
  logic [FRAC_W-1:0] frac_f;

  always_comb begin
    // After normalisation the top bit is set unless the magnitude was zero.
    nonzero = norm_i[INT_W-1];
    exp_f   = EXP_W'(TOP_EXP) - {{(EXP_W-CNT_W){1'b0}}, lz_i};
    frac_f  = {norm_i[INT_W-2:0], {PAD_W{1'b0}}};
    if (nonzero) dbl_o = {neg_i, exp_f, frac_f};
    else         dbl_o = '0;
  end
endmodule

// File: rtl/int2dbl_conv.sv
module int2dbl_conv
  import int2dbl_pkg::*;
#(
  parameter int INT_W = 52,
  parameter int LZC_W = 60
) (
  input  logic [INT_W-1:0] int_in,
  output logic [DBL_W-1:0] dbl_out
);
  localparam int PAD_W = LZC_W - INT_W;
  localparam int CNT_W = $clog2(LZC_W + 1);

  logic             neg;
  logic [INT_W-1:0] mag;
  logic [CNT_W-1:0] lz;
  logic [INT_W-1:0] norm;

  i2d_magnitude #(.W(INT_W)) u_mag (
    .value_i (int_in),
    .neg_o   (neg),
    .mag_o   (mag)
  );

  i2d_lzc #(.W(LZC_W), .CNT_W(CNT_W)) u_lzc (
    .vec_i (LZC_W'({mag, {PAD_W{1'b0}}})),
    .cnt_o (lz)
  );

  i2d_lshift #(.W(INT_W), .SH_W(CNT_W)) u_shift (
    .data_i (mag),
    .amt_i  (lz),
    .data_o (norm)
  );

  i2d_pack #(.INT_W(INT_W), .CNT_W(CNT_W)) u_pack (
    .neg_i  (neg),
    .lz_i   (lz),
    .norm_i (norm),
    .dbl_o  (dbl_out)
  );
endmodule

// File: rtl/int2dbl_conv_chk.sv
module int2dbl_conv_chk #(
  parameter int INT_W = 52
) (
  input logic [INT_W-1:0] int_in,
  input logic [63:0]      dbl_out
);
  logic [INT_W-1:0] c_mag;
  int               c_pos;

  always_comb begin
    c_mag = int_in[INT_W-1] ? (~int_in + INT_W'(1)) : int_in;
    c_pos = int'(dbl_out[62:52]) - 1023;

    a_r1_zero: assert ((int_in != '0) || (dbl_out == 64'd0))
      else $error("R1: zero input gave %h", dbl_out);

    if (int_in != '0) begin
      a_r2_sign: assert (dbl_out[63] == int_in[INT_W-1])
        else $error("R2: sign mismatch");
      a_r3_exp_pos: assert ((c_pos >= 0) && (c_pos < INT_W) && ((c_mag >> c_pos) == INT_W'(1)))
        else $error("R3: exponent %0d does not mark the leading one", c_pos);
      a_r4_frac_tail: assert ((dbl_out[51:0] & ((52'd1 << (52 - c_pos)) - 52'd1)) == 52'd0)
        else $error("R4: fraction has bits below the magnitude");
    end

    a_r7_no_special: assert ((dbl_out[62:52] != 11'h7FF) && (dbl_out != 64'h8000000000000000))
      else $error("R7: special value %h", dbl_out);
  end
endmodule

bind int2dbl_conv int2dbl_conv_chk #(.INT_W(INT_W)) i_chk (
  .int_in  (int_in),
  .dbl_out (dbl_out)
);

// File: tb/test_int2dbl_conv.sv
`timescale 1ns/1ps
module test_int2dbl_conv;
  logic        clk = 1'b0;
  logic [51:0] int_in;
  logic [63:0] dbl_out;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  int2dbl_conv i_int2dbl_conv (.int_in(int_in), .dbl_out(dbl_out));

  function automatic logic [63:0] ref_dbl(logic [51:0] v);
    longint s;
    real r;
    s = {{12{v[51]}}, v};
    r = real'(s);
    return $realtobits(r);
  endfunction

  task automatic apply(logic [51:0] v);
    @(negedge clk);
    int_in = v;
    @(posedge clk);
    #0.5;
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s in=%h actual=%h expected=%h", req, int_in, act, exp);
    end
  endtask

  task automatic fields(logic [51:0] v);
    logic [51:0] m;
    int p;
    apply(v);
    chk("R6", dbl_out, ref_dbl(v));
    m = v[51] ? -v : v;
    if (m != 0) begin
      p = 51;
      while (!m[p]) p--;
      chk("R2", 64'(dbl_out[63]), 64'(v[51]));
      chk("R3", 64'(dbl_out[62:52]), 64'(1023 + p));
      chk("R4", 64'(dbl_out[51:0]), 64'(((m << (52 - p)) & 52'hF_FFFF_FFFF_FFFF)));
    end
  endtask

  initial begin
    int unsigned seed_dummy;
    int_in = '0;
    seed_dummy = $urandom(32'h1D0C_5EED);
    // R1: zero
    apply(52'd0);
    chk("R1", dbl_out, 64'h0);
    apply(52'd1);
    chk("R6", dbl_out, 64'h3FF0000000000000);
    apply(-52'sd1);
    chk("R2", dbl_out, 64'hBFF0000000000000);
    apply(52'd3);
    chk("R4", dbl_out, 64'h4008000000000000);
    apply(-52'sd3);
    chk("R2", dbl_out, 64'hC008000000000000);
    apply(52'd2);
    chk("R3", dbl_out, 64'h4000000000000000);
    // R5: most negative value
    apply(52'h8000000000000);
    chk("R5", dbl_out, 64'hC320000000000000);
    apply(52'h7FFFFFFFFFFFF);
    chk("R3", dbl_out, 64'h431FFFFFFFFFFFFC);
    // R7: zero never turns into negative zero after a negative input
    apply(-52'sd5);
    apply(52'd0);
    chk("R7", dbl_out, 64'h0);
    for (int k = 0; k < 52; k++) fields(52'd1 << k);
    for (int k = 0; k < 2000; k++) begin
      logic [63:0] raw;
      logic [51:0] v;
      raw = {$urandom, $urandom};
      v = 52'(raw >> ($urandom % 52 + 12));
      v[51] = 1'b0;
      if ($urandom % 2 == 1) v = -v;
      fields(v);
    end
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule